// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits at the issue stage of a two-wide, in-order core. Each cycle it is shown an aligned fetch pair, made of a lead (older) slot and a trailing (younger) slot. Each slot carries a valid bit and a decoded class. The lead slot also carries three flags: it may nullify the instruction after it, it sits at an odd word address, and it was reached as the target of a taken branch. From these inputs the block decides whether both instructions may leave together.

The pairing rule is an asymmetric table indexed by the two classes, plus two overrides. A lead instruction that may nullify its follower pairs only with a floating-point follower. A lead instruction that is an odd-address branch target always goes alone.

When both slots are valid but may not pair, the lead instruction issues alone. The trailing one is parked in a one-entry holding register and issues by itself on the next unstalled cycle. On that draining cycle the fetch inputs are not consumed. A stall input freezes the holding register and issues nothing.

All outputs are registered. They are the pair decision, an issue count, and the class of the instruction placed in the lead issue slot.

Top module: `pairchk_top`

## Requirements
- R1: With both slots valid, no override active and nothing held, the pair issues together (pair_o=1, issue_cnt_o=2) exactly when the class pair is allowed. Class codes are FPU=0, MEM=1, INT=2, MEDIA=3, NOP=4, VBR=5, BR=6, SYS=7. Allowed followers, per lead class:
  - FPU: MEM, INT, MEDIA, NOP, VBR, BR.
  - MEM: FPU, INT, MEDIA, NOP, BR.
  - INT: any class except VBR.
  - MEDIA: FPU, MEM, INT, SYS.
  - NOP: FPU only.
- R2: A lead instruction of class VBR, BR or SYS never pairs.
- R3: When the lead's nullify flag is set, the pair is refused unless the follower class is FPU.
- R4: When the lead's odd-address flag and branch-target flag are both set, the pair is refused.
- R5: When exactly one slot is valid, one instruction issues (issue_cnt_o=1, pair_o=0) and lead_cls_o is that slot's class; when neither is valid, issue_cnt_o=0.
- R6: When both slots are valid and pairing is refused, issue_cnt_o=1 and lead_cls_o is the lead class. On the next unstalled cycle, the held follower issues alone: issue_cnt_o=1, pair_o=0 and lead_cls_o equal to the follower class. The fetch inputs of that cycle are ignored.
- R7: A cycle with stall_i high gives issue_cnt_o=0 and pair_o=0. A held follower survives any number of stalled cycles.
- R8: Synchronous reset clears the outputs to pair_o=0 and issue_cnt_o=0, and empties the holding register.
- R9: pair_o is 1 exactly when issue_cnt_o is 2. Each output reflects the inputs of the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Freeze issue this cycle |
| lead_vld_i | input | 1 | Older slot holds an instruction |
| lead_cls_i | input | 3 | Older slot class code |
| lead_nullify_i | input | 1 | Older instruction may nullify its follower |
| lead_odd_i | input | 1 | Older instruction is at an odd word address |
| lead_tgt_i | input | 1 | Older instruction was reached as a taken-branch target |
| trail_vld_i | input | 1 | Younger slot holds an instruction |
| trail_cls_i | input | 3 | Younger slot class code |
| pair_o | output | 1 | Both instructions issued together |
| issue_cnt_o | output | 2 | Instructions issued: 0, 1 or 2 |
| lead_cls_o | output | 3 | Class placed in the lead issue slot |

## Verification
The bench sweeps all 64 class pairs under every combination of the nullify, odd-address and branch-target flags. A table with one wrong entry, or a table read the wrong way round, fails here, and so does an override that ignores the FPU exception or needs only one of the two odd-target flags.

After every refused pair, the bench presents a pair that would itself be allowed and expects a lone drain of the parked class. This catches a design that drops the held follower or lets fresh fetch data overtake it. Further cases cover single-slot and empty fetches, stalls placed on top of a held follower, and a reset applied while something is held. A design that cleared the holding register on a stall, or kept it across reset, would issue the wrong count or class.

// File: rtl/pairchk_pkg.sv
package pairchk_pkg;

    localparam int CLS_W = 3;
    localparam int CLS_N = 1 << CLS_W;
    localparam int CNT_W = 2;

    typedef enum logic [CLS_W-1:0] {
        CL_FPU   = 3'd0,
        CL_MEM   = 3'd1,
        CL_INT   = 3'd2,
        CL_MEDIA = 3'd3,
        CL_NOP   = 3'd4,
        CL_VBR   = 3'd5,
        CL_BR    = 3'd6,
        CL_SYS   = 3'd7
    } ins_cls_e;

    typedef struct packed {
        logic     vld;
        ins_cls_e cls;
    } slot_t;

    typedef struct packed {
        logic             pair;
        logic [CNT_W-1:0] cnt;
        ins_cls_e         lead;
    } issue_t;

    // Bit k set: a follower of class k may issue beside this lead class.
    function automatic logic [CLS_N-1:0] partner_mask(ins_cls_e lead);
        logic [CLS_N-1:0] m;
        m = '0;
        case (lead)
            CL_FPU:   begin
                m[CL_MEM] = 1'b1; m[CL_INT] = 1'b1; m[CL_MEDIA] = 1'b1;
                m[CL_NOP] = 1'b1; m[CL_VBR] = 1'b1; m[CL_BR]    = 1'b1;
            end
            CL_MEM:   begin
                m[CL_FPU] = 1'b1; m[CL_INT] = 1'b1; m[CL_MEDIA] = 1'b1;
                m[CL_NOP] = 1'b1; m[CL_BR]  = 1'b1;
            end
            CL_INT:   begin
                m = '1;
                m[CL_VBR] = 1'b0;
            end
            CL_MEDIA: begin
                m[CL_FPU] = 1'b1; m[CL_MEM] = 1'b1; m[CL_INT] = 1'b1;
                m[CL_SYS] = 1'b1;
            end
            CL_NOP:   m[CL_FPU] = 1'b1;
            default:  m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pairchk_rule.sv
module pairchk_rule
    import pairchk_pkg::*;
(
    input  ins_cls_e lead_cls,
    input  ins_cls_e trail_cls,
    input  logic     nullify,
    input  logic     odd_addr,
    input  logic     br_tgt,
    output logic     pair_ok
);
    logic [CLS_N-1:0] row;
    logic             table_ok;
    logic             null_ok;
    logic             isolate;

    always_comb begin
        row      = partner_mask(lead_cls);
        table_ok = row[trail_cls];
        null_ok  = !nullify || (trail_cls == CL_FPU);
        isolate  = odd_addr && br_tgt;
        pair_ok  = table_ok && null_ok && !isolate;
    end

endmodule

// File: rtl/pairchk_seq.sv
module pairchk_seq
    import pairchk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   stall,
    input  slot_t  lead_s,
    input  slot_t  trail_s,
    input  logic   pair_ok,
    output issue_t iss
);
    logic     hold_q;
    ins_cls_e held_cls_q;
    issue_t   iss_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q     <= 1'b0;
            held_cls_q <= CL_FPU;
            iss_q      <= '{pair: 1'b0, cnt: '0, lead: CL_FPU};
        end else if (stall) begin
            iss_q.pair <= 1'b0;
            iss_q.cnt  <= '0;
        end else if (hold_q) begin
            iss_q.pair <= 1'b0;
            iss_q.cnt  <= CNT_W'(1);
            iss_q.lead <= held_cls_q;
            hold_q     <= 1'b0;
        end else begin
            unique case ({lead_s.vld, trail_s.vld})
                2'b11: begin
                    iss_q.lead <= lead_s.cls;
                    if (pair_ok) begin
                        iss_q.pair <= 1'b1;
                        iss_q.cnt  <= CNT_W'(2);
                    end else begin
                        iss_q.pair <= 1'b0;
                        iss_q.cnt  <= CNT_W'(1);
                        hold_q     <= 1'b1;
                        held_cls_q <= trail_s.cls;
                    end
                end
                2'b10: begin
                    iss_q.pair <= 1'b0;
                    iss_q.cnt  <= CNT_W'(1);
                    iss_q.lead <= lead_s.cls;
                end
                2'b01: begin
                    iss_q.pair <= 1'b0;
                    iss_q.cnt  <= CNT_W'(1);
                    iss_q.lead <= trail_s.cls;
                end
                default: begin
                    iss_q.pair <= 1'b0;
                    iss_q.cnt  <= '0;
                end
            endcase
        end
    end

    assign iss = iss_q;

    // R7: a stalled cycle issues nothing and keeps the parked follower
    p_stall_zero_r7: assert property (@(posedge clk) disable iff (rst)
        stall |=> (iss.cnt == '0) && !iss.pair);
    p_stall_keep_r7: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(hold_q));

    // R6: a parked follower drains alone on the next free cycle
    p_drain_r6: assert property (@(posedge clk) disable iff (rst)
        (hold_q && !stall) |=> (iss.cnt == CNT_W'(1)) && !iss.pair && !hold_q);
    p_park_r6: assert property (@(posedge clk) disable iff (rst)
        (!hold_q && !stall && lead_s.vld && trail_s.vld && !pair_ok)
        |=> hold_q && (iss.cnt == CNT_W'(1)));

    // R9: the pair flag and a count of two go together
    p_pair_cnt_r9: assert property (@(posedge clk) disable iff (rst)
        iss.pair == (iss.cnt == CNT_W'(2)));

endmodule

// File: rtl/pairchk_top.sv
module pairchk_top
    import pairchk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stall_i,
    input  logic       lead_vld_i,
    input  logic [2:0] lead_cls_i,
    input  logic       lead_nullify_i,
    input  logic       lead_odd_i,
    input  logic       lead_tgt_i,
    input  logic       trail_vld_i,
    input  logic [2:0] trail_cls_i,
    output logic       pair_o,
    output logic [1:0] issue_cnt_o,
    output logic [2:0] lead_cls_o
);
    slot_t  lead_s;
    slot_t  trail_s;
    logic   pair_ok;
    issue_t iss;

    assign lead_s  = '{vld: lead_vld_i,  cls: ins_cls_e'(lead_cls_i)};
    assign trail_s = '{vld: trail_vld_i, cls: ins_cls_e'(trail_cls_i)};

    pairchk_rule u_rule (
        .lead_cls  (lead_s.cls),
        .trail_cls (trail_s.cls),
        .nullify   (lead_nullify_i),
        .odd_addr  (lead_odd_i),
        .br_tgt    (lead_tgt_i),
        .pair_ok   (pair_ok)
    );

    pairchk_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .stall   (stall_i),
        .lead_s  (lead_s),
        .trail_s (trail_s),
        .pair_ok (pair_ok),
        .iss     (iss)
    );

    assign pair_o      = iss.pair;
    assign issue_cnt_o = iss.cnt;
    assign lead_cls_o  = iss.lead;

    // R2: branch-like and system leads never pair
    p_no_row_r2: assert property (@(posedge clk) disable iff (rst)
        (lead_cls_i inside {3'd5, 3'd6, 3'd7}) |=> !pair_o);
    // R3: nullifying lead pairs only with an FPU follower
    p_nullify_r3: assert property (@(posedge clk) disable iff (rst)
        (lead_nullify_i && trail_cls_i != 3'd0) |=> !pair_o);
    // R4: odd-address branch target issues alone
    p_odd_tgt_r4: assert property (@(posedge clk) disable iff (rst)
        (lead_odd_i && lead_tgt_i) |=> !pair_o);
    // R5: a lone valid slot never pairs
    p_single_r5: assert property (@(posedge clk) disable iff (rst)
        (lead_vld_i != trail_vld_i) |=> !pair_o);

endmodule

// File: tb/pairchk_top_tb_top.sv
module pairchk_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stall_i = 1'b0;
    logic       lead_vld_i = 1'b0;
    logic [2:0] lead_cls_i = 3'd0;
    logic       lead_nullify_i = 1'b0;
    logic       lead_odd_i = 1'b0;
    logic       lead_tgt_i = 1'b0;
    logic       trail_vld_i = 1'b0;
    logic [2:0] trail_cls_i = 3'd0;
    logic       pair_o;
    logic [1:0] issue_cnt_o;
    logic [2:0] lead_cls_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pairchk_top dut_i (
        .clk(clk), .rst(rst), .stall_i(stall_i),
        .lead_vld_i(lead_vld_i), .lead_cls_i(lead_cls_i),
        .lead_nullify_i(lead_nullify_i), .lead_odd_i(lead_odd_i),
        .lead_tgt_i(lead_tgt_i), .trail_vld_i(trail_vld_i),
        .trail_cls_i(trail_cls_i), .pair_o(pair_o),
        .issue_cnt_o(issue_cnt_o), .lead_cls_o(lead_cls_o)
    );

    function automatic bit expect_pair(int l, int t, bit nul, bit odd, bit tgt);
        bit ok;
        if (odd && tgt) return 1'b0;                 // R4
        case (l)
            0: ok = (t >= 1 && t <= 6);
            1: ok = (t == 0) || (t == 2) || (t == 3) || (t == 4) || (t == 6);
            2: ok = (t != 5);
            3: ok = (t <= 2) || (t == 7);
            4: ok = (t == 0);
            default: ok = 1'b0;                      // R2
        endcase
        if (nul && t != 0) ok = 1'b0;                // R3
        return ok;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(bit lv, int lc, bit nul, bit odd, bit tgt, bit tv, int tc);
        lead_vld_i     = lv;
        lead_cls_i     = 3'(lc);
        lead_nullify_i = nul;
        lead_odd_i     = odd;
        lead_tgt_i     = tgt;
        trail_vld_i    = tv;
        trail_cls_i    = 3'(tc);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
            finish_run();
        end
    end

    initial begin
        // R8: reset state
        @(negedge clk);
        step();
        chk("R8 reset pair", int'(pair_o), 0);
        chk("R8 reset cnt", int'(issue_cnt_o), 0);
        rst = 1'b0;

        // R1 R2 R3 R4 R6 R9: full sweep of both-valid pairs
        for (int f = 0; f < 8; f++) begin
            for (int l = 0; l < 8; l++) begin
                for (int t = 0; t < 8; t++) begin
                    bit ep;
                    ep = expect_pair(l, t, f[0], f[1], f[2]);
                    drive(1, l, f[0], f[1], f[2], 1, t);
                    step();
                    chk("R1 pair", int'(pair_o), int'(ep));
                    chk("R9 cnt", int'(issue_cnt_o), ep ? 2 : 1);
                    chk("R6 lead cls", int'(lead_cls_o), l);
                    if (!ep) begin
                        drive(1, 2, 0, 0, 0, 1, 2);  // would pair, must be ignored
                        step();
                        chk("R6 drain cnt", int'(issue_cnt_o), 1);
                        chk("R6 drain pair", int'(pair_o), 0);
                        chk("R6 drain cls", int'(lead_cls_o), t);
                    end
                end
            end
        end

        // R5: single and empty fetches
        for (int c = 0; c < 8; c++) begin
            drive(1, c, 0, 0, 0, 0, 7 - c);
            step();
            chk("R5 lead only cnt", int'(issue_cnt_o), 1);
            chk("R5 lead only pair", int'(pair_o), 0);
            chk("R5 lead only cls", int'(lead_cls_o), c);
            drive(0, 7 - c, 0, 0, 0, 1, c);
            step();
            chk("R5 trail only cnt", int'(issue_cnt_o), 1);
            chk("R5 trail only cls", int'(lead_cls_o), c);
        end
        drive(0, 2, 0, 0, 0, 0, 2);
        step();
        chk("R5 empty cnt", int'(issue_cnt_o), 0);
        chk("R5 empty pair", int'(pair_o), 0);

        // R7: stall over a parked follower (INT then VBR is refused)
        drive(1, 2, 0, 0, 0, 1, 5);
        step();
        chk("R7 park cnt", int'(issue_cnt_o), 1);
        stall_i = 1'b1;
        drive(1, 0, 0, 0, 0, 1, 1);
        step();
        chk("R7 stall cnt", int'(issue_cnt_o), 0);
        chk("R7 stall pair", int'(pair_o), 0);
        step();
        chk("R7 stall2 cnt", int'(issue_cnt_o), 0);
        stall_i = 1'b0;
        step();
        chk("R7 held survives cnt", int'(issue_cnt_o), 1);
        chk("R7 held survives cls", int'(lead_cls_o), 5);
        step();
        chk("R7 resume pair", int'(pair_o), 1);
        chk("R7 resume cnt", int'(issue_cnt_o), 2);

        // R7: stall with nothing parked and an allowed pair
        stall_i = 1'b1;
        drive(1, 3, 0, 0, 0, 1, 7);
        step();
        chk("R7 stall pair-ready cnt", int'(issue_cnt_o), 0);
        stall_i = 1'b0;
        step();
        chk("R7 after stall pair", int'(pair_o), 1);

        // R8: reset while a follower is parked
        drive(1, 4, 0, 0, 0, 1, 2);
        step();
        chk("R8 park before reset", int'(issue_cnt_o), 1);
        rst = 1'b1;
        step();
        chk("R8 mid reset cnt", int'(issue_cnt_o), 0);
        rst = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 0);
        step();
        chk("R8 hold cleared cnt", int'(issue_cnt_o), 0);

        finish_run();
    end

endmodule